// File: doc/BRIEF.md
# Multi-Lane Serial Bus Front End

This block sits at the pin side of a serial memory slave whose bus can run one, two or four data lanes wide. It samples the serial clock, chip select and the four data pins on its own system clock, finds the serial clock edges, and keeps the active lane width in a register that survives from one chip-select frame to the next. In-band opcodes widen the bus to two or four lanes or bring it back to one lane, and each of these opcodes is clocked in at the width that is active when it arrives.

Incoming bits are gathered into bytes and handed to a command engine with a marker on the opcode byte. For the two read opcodes the block switches to an output phase: it asks the engine for each outgoing byte, shifts it out most significant bits first at the active width, and enables only the lanes that width uses. A memory read in a two- or four-lane mode returns a zero turnaround byte before the first data byte. Raising chip select ends a frame at once, drops any half-received byte and turns every output enable off.

Top module: `mlane_sio_front`

## Requirements
- R1: During and straight after reset the lane mode is single (lane_mode = 0), all output enables are 0 and rx_valid is 0.
- R2: An opcode byte of 0x3B sets lane_mode to 1 (two lanes), 0x38 sets it to 2 (four lanes) and 0xFF sets it to 0 (one lane); 0xFF takes 8, 4 or 2 serial clocks in one, two or four lane mode.
- R3: Input bits are taken on rising serial clock edges, most significant first: one lane uses sio_in[0]; two lanes carry the higher bit on sio_in[1]; four lanes carry a nibble with its top bit on sio_in[3]. A byte takes 8, 4 or 2 clocks.
- R4: Every byte completed outside the data-out phase raises rx_valid for one system clock with rx_data; rx_first is 1 only for the first byte of a frame.
- R5: The values 0x3B, 0x38 and 0xFF leave lane_mode unchanged when they arrive as any byte other than the first of a frame.
- R6: Output bits change only after a falling serial clock edge and leave most significant first with the lane mapping of R3, except that one-lane output uses sio_out[1].
- R7: Opcode 0x03 enters the data-out phase after three address bytes; in two- and four-lane modes the first byte sent is 0x00 and engine data follows. Opcode 0x05 enters the data-out phase directly with no turnaround byte.
- R8: tx_req pulses for one system clock when the data-out phase needs its next engine byte: at the end of the byte before each data byte, so n data bytes need n+1 pulses up to the end of the last one. tx_data is taken at the next falling serial clock edge.
- R9: Output enables are 4'b0010, 4'b0011 or 4'b1111 for one, two or four lanes, only in the data-out phase from its first falling edge, and 0 whenever cs_n is high.
- R10: lane_mode keeps its value across chip-select frames.
- R11: A frame closed partway through a byte delivers no byte, and the next frame starts with a fresh bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, already synchronized |
| cs_n | input | 1 | Chip select, active low, already synchronized |
| sio_in | input | 4 | Data pin input levels, lane 0 to lane 3 |
| sio_out | output | 4 | Data pin output levels |
| sio_oe | output | 4 | Output enable per data pin |
| lane_mode | output | 2 | Active width: 0 one lane, 1 two lanes, 2 four lanes |
| rx_valid | output | 1 | One-clock pulse with a received byte |
| rx_first | output | 1 | Received byte is the opcode of the frame |
| rx_data | output | 8 | Received byte |
| tx_req | output | 1 | Request for the next outgoing byte |
| tx_data | input | 8 | Outgoing byte from the command engine |

## Verification
Writes are sent at each of the three widths with bytes whose bits differ across lanes, so a swapped lane, a wrong bit order or a wrong clocks-per-byte count shows as a mismatched byte in the scoreboard. Reads at each width check the turnaround byte, the absence of it for the single-lane read and the register read, the enable mask and the request count. Mode opcodes placed in address and data positions separate opcode decoding from plain byte matching, and a frame cut after six bits shows whether a stale bit count leaks into the next frame. The return to one lane is sent from both wider modes to show it is clocked at the active width.

// File: rtl/mlane_pkg.sv
// Shared types and constants of the multi-lane serial front end.
package mlane_pkg;

    localparam int BYTE_W = 8;
    localparam int TICK_W = 3;

    typedef enum logic [1:0] {
        LM_X1 = 2'd0,
        LM_X2 = 2'd1,
        LM_X4 = 2'd2
    } lane_mode_e;

    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_ADR = 2'd1,
        PH_OUT = 2'd2,
        PH_PAY = 2'd3
    } phase_e;

    localparam logic [BYTE_W-1:0] OPC_READ   = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_RDMODE = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_GO_X2  = 8'h3B;
    localparam logic [BYTE_W-1:0] OPC_GO_X4  = 8'h38;
    localparam logic [BYTE_W-1:0] OPC_GO_X1  = 8'hFF;

    // Index of the last serial clock of a byte at a given width.
    function automatic logic [TICK_W-1:0] last_tick(input lane_mode_e m);
        case (m)
            LM_X2:   last_tick = TICK_W'(3);
            LM_X4:   last_tick = TICK_W'(1);
            default: last_tick = TICK_W'(7);
        endcase
    endfunction

endpackage

// File: rtl/mlane_edge.sv
// Serial clock edge finder.
// Assumes sck is already synchronized to clk and that each sck level
// lasts at least two clk cycles. Produces one-cycle rise/fall strobes.
module mlane_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    // Keep the previous sck level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;

endmodule

// File: rtl/mlane_rx.sv
// Input shifter and per-byte clock counter.
// Gathers 1, 2 or 4 bits per rising serial edge, most significant first,
// and flags a completed byte. Assumes the lane mode only changes on a
// byte boundary. Chip select high clears the count and any partial byte.
module mlane_rx
    import mlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  lane_mode_e        mode,
    input  logic [3:0]        sio_in,
    output logic [TICK_W-1:0] tick,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_next;

    // Merge the lanes of this clock into the shift value.
    always_comb begin
        case (mode)
            LM_X2:   sh_next = {sh_q[BYTE_W-3:0], sio_in[1], sio_in[0]};
            LM_X4:   sh_next = {sh_q[BYTE_W-5:0], sio_in[3:0]};
            default: sh_next = {sh_q[BYTE_W-2:0], sio_in[0]};
        endcase
    end

    assign byte_done = rise & ~cs_n & (tick == last_tick(mode));
    assign byte_val  = sh_next;

    // Advance the shift register and clock count on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            tick <= '0;
        end else if (cs_n) begin
            sh_q <= '0;
            tick <= '0;
        end else if (rise) begin
            sh_q <= sh_next;
            tick <= byte_done ? '0 : tick + TICK_W'(1);
        end
    end

    a_r11_tick_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (tick == '0));

    a_r3_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= last_tick(mode));

endmodule

// File: rtl/mlane_seq.sv
// Frame sequencer and lane-mode register.
// Decodes the opcode byte, counts address bytes, decides when the
// data-out phase starts, whether a turnaround byte comes first and when
// to ask the engine for a byte. The mode register survives frames.
module mlane_seq
    import mlane_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              load_evt,
    output lane_mode_e        lane_mode,
    output phase_e            phase,
    output logic              dummy_pend,
    output logic              rx_valid,
    output logic              rx_first,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req
);
    localparam int AW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [AW-1:0] ADR_LAST = AW'(ADDR_BYTES - 1);

    logic [AW-1:0] adr_cnt;

    // Step the frame phase and the mode register on completed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_mode  <= LM_X1;
            phase      <= PH_OPC;
            adr_cnt    <= '0;
            dummy_pend <= 1'b0;
            rx_valid   <= 1'b0;
            rx_first   <= 1'b0;
            rx_data    <= '0;
            tx_req     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (cs_n) begin
                phase      <= PH_OPC;
                adr_cnt    <= '0;
                dummy_pend <= 1'b0;
            end else begin
                if (load_evt) dummy_pend <= 1'b0;
                if (byte_done) begin
                    if (phase != PH_OUT) begin
                        rx_valid <= 1'b1;
                        rx_data  <= byte_val;
                        rx_first <= (phase == PH_OPC);
                    end
                    case (phase)
                        PH_OPC: begin
                            case (byte_val)
                                OPC_GO_X2: begin lane_mode <= LM_X2; phase <= PH_PAY; end
                                OPC_GO_X4: begin lane_mode <= LM_X4; phase <= PH_PAY; end
                                OPC_GO_X1: begin lane_mode <= LM_X1; phase <= PH_PAY; end
                                OPC_READ:  begin phase <= PH_ADR; adr_cnt <= '0; end
                                OPC_RDMODE: begin phase <= PH_OUT; tx_req <= 1'b1; end
                                default:   phase <= PH_PAY;
                            endcase
                        end
                        PH_ADR: begin
                            if (adr_cnt == ADR_LAST) begin
                                phase <= PH_OUT;
                                if (lane_mode == LM_X1) tx_req <= 1'b1;
                                else                    dummy_pend <= 1'b1;
                            end else begin
                                adr_cnt <= adr_cnt + AW'(1);
                            end
                        end
                        PH_OUT:  tx_req <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    a_r2_mode_moves_on_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode != $past(lane_mode)) |-> ($past(byte_done) && ($past(phase) == PH_OPC)));

    a_r8_req_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    a_r7_dummy_only_wide: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_pend |-> (lane_mode != LM_X1));

    a_r4_valid_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/mlane_tx.sv
// Output shifter and lane enables.
// In the data-out phase loads a byte (engine byte or zero turnaround)
// on the first falling edge of each byte and shifts 1, 2 or 4 bits per
// later falling edge. Enables follow the lane width while driving and
// drop as soon as chip select goes high.
module mlane_tx
    import mlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fall,
    input  logic [TICK_W-1:0] tick,
    input  lane_mode_e        mode,
    input  phase_e            phase,
    input  logic              dummy_pend,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [3:0]        sio_out,
    output logic [3:0]        sio_oe,
    output logic              load_evt
);
    logic [BYTE_W-1:0] osh;
    logic              drv_on;
    logic [3:0]        lane_mask;

    assign load_evt = fall & ~cs_n & (phase == PH_OUT) & (tick == '0);

    // Load or shift the outgoing byte on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osh    <= '0;
            drv_on <= 1'b0;
        end else if (cs_n) begin
            osh    <= '0;
            drv_on <= 1'b0;
        end else if (fall && phase == PH_OUT) begin
            drv_on <= 1'b1;
            if (tick == '0) begin
                osh <= dummy_pend ? '0 : tx_data;
            end else begin
                case (mode)
                    LM_X2:   osh <= osh << 2;
                    LM_X4:   osh <= osh << 4;
                    default: osh <= osh << 1;
                endcase
            end
        end
    end

    // Map the top bits of the shifter onto the lanes.
    always_comb begin
        case (mode)
            LM_X2: begin
                sio_out   = {2'b00, osh[BYTE_W-1], osh[BYTE_W-2]};
                lane_mask = 4'b0011;
            end
            LM_X4: begin
                sio_out   = osh[BYTE_W-1:BYTE_W-4];
                lane_mask = 4'b1111;
            end
            default: begin
                sio_out   = {2'b00, osh[BYTE_W-1], 1'b0};
                lane_mask = 4'b0010;
            end
        endcase
        sio_oe = (drv_on && !cs_n) ? lane_mask : 4'b0000;
    end

    a_r6_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sio_out) |-> ($past(fall) || $past(cs_n)));

endmodule

// File: rtl/mlane_sio_front.sv
// Multi-lane serial bus front end, top level.
// Ties together edge detection, input shifting, frame sequencing and
// output shifting. Assumes sck, cs_n and sio_in are synchronized to clk
// and that sck levels last at least two clk cycles.
module mlane_sio_front
    import mlane_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        sio_in,
    output logic [3:0]        sio_out,
    output logic [3:0]        sio_oe,
    output logic [1:0]        lane_mode,
    output logic              rx_valid,
    output logic              rx_first,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_req,
    input  logic [BYTE_W-1:0] tx_data
);
    logic              rise, fall;
    logic [TICK_W-1:0] tick;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              load_evt;
    logic              dummy_pend;
    lane_mode_e        mode;
    phase_e            phase;

    mlane_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sck  (sck),
        .rise (rise),
        .fall (fall)
    );

    mlane_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rise     (rise),
        .mode     (mode),
        .sio_in   (sio_in),
        .tick     (tick),
        .byte_done(byte_done),
        .byte_val (byte_val)
    );

    mlane_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .load_evt  (load_evt),
        .lane_mode (mode),
        .phase     (phase),
        .dummy_pend(dummy_pend),
        .rx_valid  (rx_valid),
        .rx_first  (rx_first),
        .rx_data   (rx_data),
        .tx_req    (tx_req)
    );

    mlane_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .fall      (fall),
        .tick      (tick),
        .mode      (mode),
        .phase     (phase),
        .dummy_pend(dummy_pend),
        .tx_data   (tx_data),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe),
        .load_evt  (load_evt)
    );

    assign lane_mode = mode;

    a_r9_oe_only_out_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe != 4'b0000) |-> (phase == PH_OUT));

    a_r4_no_rx_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_OUT) |=> !rx_valid);

endmodule

// File: tb/sim_mlane_sio_front.sv
`timescale 1ns/1ps
module sim_mlane_sio_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] sio_in = 4'h0;
    logic [3:0] sio_out, sio_oe;
    logic [1:0] lane_mode;
    logic       rx_valid, rx_first, tx_req;
    logic [7:0] rx_data;
    logic [7:0] tx_data = 8'h00;

    int checks = 0;
    int fails = 0;
    int nreq = 0;
    int bm = 0;            // bench copy of the lane mode
    logic [3:0] last_oe;
    logic [8:0] exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    mlane_sio_front u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sio_in(sio_in),
        .sio_out(sio_out), .sio_oe(sio_oe), .lane_mode(lane_mode),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
        .tx_req(tx_req), .tx_data(tx_data)
    );

    function automatic logic [7:0] src_val(input int i);
        return 8'h5A ^ 8'(i * 19);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Engine model: answers each request with the next source byte (R8).
    always @(negedge clk) begin
        if (tx_req) begin
            tx_data <= src_val(nreq);
            nreq <= nreq + 1;
        end
    end

    // Scoreboard monitor: pops the expected received bytes (R3, R4).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected byte", {rx_first, rx_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({rx_first, rx_data} == e, "R3/R4 received byte", {rx_first, rx_data}, e);
            end
        end
    end

    task automatic sclk(input logic [3:0] din, output logic [3:0] dout);
        sio_in = din;
        repeat (2) @(negedge clk);
        dout = sio_out;
        last_oe = sio_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit expect_rx, input bit first);
        logic [7:0] t;
        logic [3:0] d;
        int n;
        t = b;
        n = (bm == 0) ? 8 : (bm == 1) ? 4 : 2;
        if (expect_rx) exp_q.push_back({first, b});
        for (int i = 0; i < n; i++) begin
            if (bm == 0)      begin sclk({3'b000, t[7]}, d); t = t << 1; end
            else if (bm == 1) begin sclk({2'b00, t[7:6]}, d); t = t << 2; end
            else              begin sclk(t[7:4], d); t = t << 4; end
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic [3:0] d;
        int n;
        b = 8'h00;
        n = (bm == 0) ? 8 : (bm == 1) ? 4 : 2;
        for (int i = 0; i < n; i++) begin
            sclk(4'h0, d);
            if (bm == 0)      b = {b[6:0], d[1]};
            else if (bm == 1) b = {b[5:0], d[1:0]};
            else              b = {b[3:0], d};
        end
    endtask

    task automatic frame_on();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_off();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [3:0] mask_of(input int m);
        return (m == 0) ? 4'b0010 : (m == 1) ? 4'b0011 : 4'b1111;
    endfunction

    // Memory read: opcode, three address bytes, optional turnaround, data.
    task automatic do_read(input int nbytes, input string tag);
        logic [7:0] b;
        int sp0;
        frame_on();
        sp0 = nreq;
        send_byte(8'h03, 1, 1);
        send_byte(8'h01, 1, 0);
        send_byte(8'h3B, 1, 0);
        send_byte(8'hC4, 1, 0);
        if (bm != 0) begin
            recv_byte(b);
            check(b == 8'h00, {"R7 turnaround byte ", tag}, b, 0);
            check(last_oe == mask_of(bm), {"R9 enables in turnaround ", tag}, last_oe, mask_of(bm));
        end
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(b);
            check(b == src_val(sp0 + k), {"R6/R7 read data ", tag}, b, src_val(sp0 + k));
            check(last_oe == mask_of(bm), {"R9 enables while sending ", tag}, last_oe, mask_of(bm));
        end
        check(nreq - sp0 == nbytes + 1, {"R8 request count ", tag}, nreq - sp0, nbytes + 1);
        cs_n = 1'b1;
        repeat (1) @(negedge clk);
        check(sio_oe == 4'b0000, {"R9 enables off after deselect ", tag}, sio_oe, 0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int sp0;
        repeat (5) @(negedge clk);
        check(lane_mode == 2'd0, "R1 mode in reset", lane_mode, 0);
        check(sio_oe == 4'b0000, "R1 enables in reset", sio_oe, 0);
        check(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(lane_mode == 2'd0, "R1 mode after reset", lane_mode, 0);

        // Single-lane write (R3, R4).
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'h01, 1, 0);
        send_byte(8'h23, 1, 0);
        send_byte(8'h45, 1, 0);
        send_byte(8'hD6, 1, 0);
        send_byte(8'h7E, 1, 0);
        frame_off();
        check(exp_q.size() == 0, "R4 all single bytes seen", exp_q.size(), 0);

        // Single-lane read: no turnaround (R7), lane 1 only (R9).
        do_read(2, "x1");

        // Enter two lanes (R2) and keep it across frames (R10).
        frame_on();
        send_byte(8'h3B, 1, 1);
        frame_off();
        bm = 1;
        check(lane_mode == 2'd1, "R2 enter two lanes", lane_mode, 1);
        repeat (40) @(negedge clk);
        check(lane_mode == 2'd1, "R10 mode kept while idle", lane_mode, 1);

        // Two-lane write (R3).
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'h11, 1, 0);
        send_byte(8'h22, 1, 0);
        send_byte(8'h33, 1, 0);
        send_byte(8'h9C, 1, 0);
        frame_off();
        check(lane_mode == 2'd1, "R10 mode kept after write frame", lane_mode, 1);
        check(exp_q.size() == 0, "R3 all two-lane bytes seen", exp_q.size(), 0);

        // Two-lane read with turnaround (R7, R9).
        do_read(2, "x2");

        // Frame cut after six bits (R11).
        frame_on();
        begin
            logic [3:0] d;
            sclk(4'h3, d);
            sclk(4'h2, d);
            sclk(4'h1, d);
        end
        frame_off();
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'hA5, 1, 0);
        frame_off();
        check(exp_q.size() == 0, "R11 fresh count after cut frame", exp_q.size(), 0);

        // Mode values in non-opcode positions (R5).
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'h38, 1, 0);
        send_byte(8'hFF, 1, 0);
        send_byte(8'h3B, 1, 0);
        send_byte(8'h38, 1, 0);
        frame_off();
        check(lane_mode == 2'd1, "R5 mode unchanged by data bytes", lane_mode, 1);

        // Two lanes back to one lane with 0xFF in four clocks (R2).
        frame_on();
        send_byte(8'hFF, 1, 1);
        frame_off();
        bm = 0;
        check(lane_mode == 2'd0, "R2 return from two lanes", lane_mode, 0);

        // Enter four lanes (R2).
        frame_on();
        send_byte(8'h38, 1, 1);
        frame_off();
        bm = 2;
        check(lane_mode == 2'd2, "R2 enter four lanes", lane_mode, 2);

        // Four-lane write (R3).
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'hE1, 1, 0);
        send_byte(8'h5B, 1, 0);
        frame_off();

        // Mode register read: no turnaround even in four lanes (R7).
        frame_on();
        sp0 = nreq;
        send_byte(8'h05, 1, 1);
        recv_byte(b);
        check(b == src_val(sp0), "R7 register read no turnaround", b, src_val(sp0));
        check(last_oe == 4'b1111, "R9 four-lane enables", last_oe, 4'hF);
        frame_off();

        // Four-lane read with turnaround (R7).
        do_read(2, "x4");

        // Four lanes back to one lane in two clocks (R2).
        frame_on();
        send_byte(8'hFF, 1, 1);
        frame_off();
        bm = 0;
        check(lane_mode == 2'd0, "R2 return from four lanes", lane_mode, 0);

        // Single lane works again after the return (R3).
        frame_on();
        send_byte(8'h02, 1, 1);
        send_byte(8'h96, 1, 0);
        frame_off();
        check(exp_q.size() == 0, "R3 queue drained at end", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule